// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for one read or write burst of a synchronous DRAM controller. A one-cycle start request captures a 10-bit start column, a 3-bit length code and an ordering bit. From the next cycle the block presents one column per clock, together with a valid flag and a flag that marks the final beat.

Two orderings are supported. Sequential ordering counts upward inside the aligned block of burst length. Interleaved ordering XORs the beat index into the low start-column bits. A full-page mode, available with sequential ordering only, walks the whole 1024-column row and wraps from the top column to column 0. It keeps running until it is stopped.

A terminate input ends any burst in progress. A new start request replaces a running burst on any cycle.

A three-state machine controls the block:
- `ST_IDLE`: no burst.
- `ST_BURST`: a burst of fixed length.
- `ST_PAGE`: a full-page burst.

Transitions:
- IDLE→BURST, or IDLE→PAGE, on start, chosen by the decoded length.
- BURST→BURST and PAGE→PAGE on each advancing beat.
- BURST→IDLE on the final beat or on terminate.
- PAGE→IDLE on terminate.
- Any state → BURST or PAGE on start (restart). Start has priority over terminate.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low.
- R2: The cycle after `start_i` is sampled high, `valid_o` is high and `col_o` equals the captured start column (beat 0).
- R3: Length code decoding is 000→1 beat, 001→2, 010→4, 011→8, 111→full page (sequential type only). Codes 100, 101 and 110 give 1 beat. A finite burst holds `valid_o` high for exactly that many cycles and then drops it, unless a start arrives.
- R4: With `type_ilv_i`=0, the column of beat n keeps the start column's bits above log2(BL). Its low log2(BL) bits equal (start low bits + n) mod BL.
- R5: With `type_ilv_i`=1, beat n replaces the low log2(BL) bits with (start low bits XOR n). Interleave combined with code 111 gives a 1-beat burst.
- R6: `last_o` is high only together with `valid_o`, and only on beat BL−1 of a finite burst. It is never high in full-page mode.
- R7: In full-page mode the column rises by one per cycle, wraps from 1023 to 0, and `valid_o` stays high until a terminate or a start.
- R8: When `term_i` is high and `start_i` is low, `valid_o` is low in the next cycle. A terminate while idle has no effect.
- R9: A start during a burst, including its last beat, begins the new sequence in the next cycle. A start and a terminate in the same cycle act as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 10 | Start column for the burst |
| len_code_i | input | 3 | Burst length code |
| type_ilv_i | input | 1 | 0 sequential, 1 interleaved |
| term_i | input | 1 | Stop the running burst |
| col_o | output | 10 | Current column |
| valid_o | output | 1 | Column is a live beat |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
Terminate and a new start can fall in the same cycle. A start can also coincide with the natural final beat of a burst. The bench raises start and terminate together in the middle of an 8-beat interleaved burst, and separately issues a start on the last beat of a 2-beat burst. In both cases it judges that the next cycle shows beat 0 of the new sequence with `valid_o` high, rather than an idle cycle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } cg_state_e;

    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;
    localparam int         LEN_CODE_MAX_FINITE = 3;

endpackage

// File: rtl/cg_len_decode.sv
module cg_len_decode
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);

    logic finite_ok;

    assign page_o    = (code_i == LEN_CODE_PAGE) && !ilv_i;
    assign finite_ok = int'(code_i) <= LEN_CODE_MAX_FINITE;

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = page_o | (finite_ok && (i < int'(code_i)));
    end

endmodule

// File: rtl/cg_beat_ctr.sv
module cg_beat_ctr #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [COL_W-1:0] beat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_o <= '0;
        end else if (clear_i) begin
            beat_o <= '0;
        end else if (adv_i) begin
            beat_o <= beat_o + 1'b1;
        end
    end

endmodule

// File: rtl/cg_col_form.sv
module cg_col_form #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    assign low_seq = base_i + beat_i;
    assign low_ilv = base_i ^ beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = mask_i[i] ? (ilv_i ? low_ilv[i] : low_seq[i]) : base_i[i];
    end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             type_ilv_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    cg_state_e        state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             load;
    logic             adv;
    logic             at_end;

    cg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .ilv_i  (type_ilv_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    cg_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .adv_i   (adv),
        .beat_o  (beat)
    );

    cg_col_form #(.COL_W(COL_W)) u_form (
        .base_i (base_q),
        .beat_i (beat),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (col_o)
    );

    assign at_end = (beat == mask_q);

    // next-state and control
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = dec_page ? ST_PAGE : ST_BURST;
                end
            end
            ST_BURST: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = dec_page ? ST_PAGE : ST_BURST;
                end else if (term_i || at_end) begin
                    state_d = ST_IDLE;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_PAGE: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = dec_page ? ST_PAGE : ST_BURST;
                end else if (term_i) begin
                    state_d = ST_IDLE;
                end else begin
                    adv = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and burst parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                base_q <= start_col_i;
                mask_q <= dec_mask;
                ilv_q  <= type_ilv_i;
            end
        end
    end

    // outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BURST: begin
                valid_o = 1'b1;
                last_o  = at_end;
            end
            ST_PAGE:  valid_o = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/cg_chk.sv
module cg_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    // R6
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R2
    start_loads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R8
    term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> !valid_o);

    // R3
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R7
    burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !term_i) |=> valid_o);

endmodule

bind burst_colgen cg_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       type_ilv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o;
    logic       last_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .type_ilv_i(type_ilv_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    typedef struct packed {
        logic [9:0]  col;
        logic [2:0]  code;
        logic        ilv;
        logic [31:0] beats;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{col: 10'd13,  code: 3'd3, ilv: 1'b0, beats: 32'd8},  // R4 BL8 seq
        '{col: 10'd13,  code: 3'd3, ilv: 1'b1, beats: 32'd8},  // R5 BL8 ilv
        '{col: 10'd6,   code: 3'd2, ilv: 1'b0, beats: 32'd4},  // R4 BL4 seq
        '{col: 10'd6,   code: 3'd2, ilv: 1'b1, beats: 32'd4},  // R5 BL4 ilv
        '{col: 10'd1023,code: 3'd1, ilv: 1'b0, beats: 32'd2},  // R4 BL2 top
        '{col: 10'd511, code: 3'd1, ilv: 1'b1, beats: 32'd2},  // R5 BL2 ilv
        '{col: 10'd77,  code: 3'd0, ilv: 1'b0, beats: 32'd1},  // R3 BL1
        '{col: 10'd300, code: 3'd5, ilv: 1'b0, beats: 32'd1},  // R3 reserved code
        '{col: 10'd301, code: 3'd7, ilv: 1'b1, beats: 32'd1},  // R5 ilv + page code
        '{col: 10'd1022,code: 3'd3, ilv: 1'b1, beats: 32'd8}   // R5 top block
    };

    function automatic int exp_col(int base, int bl, bit ilv, int n);
        int blk, off;
        blk = (base / bl) * bl;
        off = base % bl;
        if (ilv) return blk + (off ^ n);
        return blk + ((off + n) % bl);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at negedge, return at next negedge showing beat 0
    task automatic launch(int col, int code, bit ilv, bit term);
        start_i     = 1'b1;
        start_col_i = 10'(col);
        len_code_i  = 3'(code);
        type_ilv_i  = ilv;
        term_i      = term;
        @(negedge clk);
        start_i = 1'b0;
        term_i  = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 last", int'(last_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2, R3, R4, R5, R6
        for (int v = 0; v < NV; v++) begin
            int bl;
            case (VECS[v].code)
                3'd0: bl = 1;
                3'd1: bl = 2;
                3'd2: bl = 4;
                3'd3: bl = 8;
                default: bl = 1;
            endcase
            launch(int'(VECS[v].col), int'(VECS[v].code), VECS[v].ilv, 1'b0);
            for (int n = 0; n < int'(VECS[v].beats); n++) begin
                chk(VECS[v].ilv ? "R5 col" : "R4 col", int'(col_o),
                    exp_col(int'(VECS[v].col), bl, VECS[v].ilv, n));
                chk("R2 valid", int'(valid_o), 1);
                chk("R6 last", int'(last_o), (n == int'(VECS[v].beats) - 1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R3 end of burst", int'(valid_o), 0);
            @(negedge clk);
        end

        // R7 full page wrap
        launch(1020, 7, 1'b0, 1'b0);
        for (int n = 0; n < 12; n++) begin
            chk("R7 col", int'(col_o), (1020 + n) % 1024);
            chk("R7 last", int'(last_o), 0);
            @(negedge clk);
        end
        chk("R7 still valid", int'(valid_o), 1);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 page term", int'(valid_o), 0);

        // R8 terminate mid burst
        launch(40, 3, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R8 beat2", int'(col_o), 42);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 term", int'(valid_o), 0);

        // R8 terminate while idle
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 idle term valid", int'(valid_o), 0);
        chk("R8 idle term last", int'(last_o), 0);

        // R9 restart mid burst, with terminate in same cycle
        launch(8, 3, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R9 old beat2", int'(col_o), 10);
        launch(100, 2, 1'b0, 1'b1);
        chk("R9 restart col", int'(col_o), 100);
        chk("R9 restart valid", int'(valid_o), 1);
        @(negedge clk);
        chk("R9 restart beat1", int'(col_o), 101);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;

        // R9 start on last beat
        launch(5, 1, 1'b0, 1'b0);
        chk("R4 BL2 beat0", int'(col_o), 5);
        @(negedge clk);
        chk("R4 BL2 beat1", int'(col_o), 4);
        chk("R6 BL2 last", int'(last_o), 1);
        launch(200, 0, 1'b0, 1'b0);
        chk("R9 on-last col", int'(col_o), 200);
        chk("R9 on-last valid", int'(valid_o), 1);
        chk("R9 on-last BL1 last", int'(last_o), 1);
        @(negedge clk);
        chk("R3 BL1 done", int'(valid_o), 0);

        // R9 restart a page burst into an interleaved one
        launch(500, 7, 1'b0, 1'b0);
        @(negedge clk);
        launch(21, 2, 1'b1, 1'b0);
        for (int n = 0; n < 4; n++) begin
            chk("R9 page->ilv col", int'(col_o), 20 + (1 ^ n));
            @(negedge clk);
        end
        chk("R9 page->ilv end", int'(valid_o), 0);

        finish_up();
    end

endmodule